// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

An 8-bit up-counter advances on a prescaled count-enable input and watches for the wrap from all-ones to zero. The timer runs in one of two modes. In watchdog mode a wrap latches an overflow flag. If the reset-enable bit is set, the wrap also starts a fixed-length internal reset request. In interval mode a wrap gives a single-cycle interrupt pulse and the counter keeps running. A small byte-wide register port lets software start and stop the timer, reload the count and inspect or acknowledge the overflow.

The overflow flag needs a deliberate two-step acknowledge. Software must first read the flag as 1, and only then does a write of 0 clear it. The reset status register is reset only by the pin reset. Its settings therefore survive the reset that the watchdog itself requests, so software can see after restart that a watchdog event took place.

Register map (byte data, 2-bit address):
- Address 0, timer control: bit 0 selects the mode (1 = watchdog, 0 = interval) and bit 1 is the run enable. All other bits read 0.
- Address 1: the count value, readable and writable.
- Address 2, reset status: bit 7 is the overflow flag, bit 6 is the reset enable, bit 5 is a spare bit, and bits 4..0 are constant ones.
- Address 3 reads 0.

Top module: `wdrc_top`

## Requirements
- R1: After pin reset (`rst` high, sampled on a clock edge) the reset status register reads 0x1F. Timer control and count read 0, and `sys_rst_req` and `ivl_irq` are low.
- R2: While the run bit is 1, the count rises by one on each clock with `tick` high and wraps modulo 256. While the run bit is 0, or with no `tick`, the count holds. A write to address 1 loads the count.
- R3: In watchdog mode the wrap from 0xFF to 0x00 sets bit 7 of the reset status register.
- R4: In interval mode a wrap leaves bit 7 clear and raises `ivl_irq` for exactly one cycle after the wrapping edge. The counter keeps its run state and continues from 0.
- R5: With bit 6 set, a watchdog-mode wrap holds `sys_rst_req` high for exactly 16 cycles. During that time the count stays 0.
- R6: With bit 6 clear, a watchdog-mode wrap produces no `sys_rst_req`. The count and the timer control register still return to 0.
- R7: A watchdog-mode wrap clears timer control to 0 but leaves bits 6 and 5 of the reset status register unchanged.
- R8: Bit 7 clears only on a write of 0 to address 2 that comes after a read of address 2 that returned bit 7 as 1. Any write to address 2 cancels that arming. Writing 1 to bit 7 never changes it.
- R9: Bit 5 reads back what was written and does not affect operation. Bits 4..0 always read 1 and ignore writes.
- R10: If a watchdog wrap and an armed clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high pin reset |
| tick | input | 1 | Prescaled count enable |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe (arms the flag clear) |
| bus_rdata | output | 8 | Read data, combinational from address |
| sys_rst_req | output | 1 | Internal reset request pulse |
| ivl_irq | output | 1 | Interval-mode overflow interrupt |

## Verification
A watchdog wrap that sets the overflow flag can land in the same clock as an armed write of 0 that would clear it. The bench provokes this with a single task. That task drives `tick` onto a count of 0xFF in watchdog mode while it writes 0 to address 2, right after a read that returned the flag as 1. The following read must show the flag still set. A further write of 0 without a new read must also leave it set, because the colliding write consumed the arming.

// File: rtl/wdrc_pkg.sv
package wdrc_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        A_TCTL = 2'd0,
        A_TCNT = 2'd1,
        A_RSC  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic run;
        logic wdog;
    } tctl_t;

    typedef struct packed {
        logic flag;
        logic rst_en;
        logic spare;
    } rsc_t;

    function automatic logic [DATA_W-1:0] pack_rsc(rsc_t s);
        logic [DATA_W-1:0] v;
        v = '1;
        v[DATA_W-1] = s.flag;
        v[DATA_W-2] = s.rst_en;
        v[DATA_W-3] = s.spare;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_tctl(tctl_t t);
        logic [DATA_W-1:0] v;
        v = '0;
        v[1] = t.run;
        v[0] = t.wdog;
        return v;
    endfunction

endpackage

// File: rtl/wdrc_counter.sv
module wdrc_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             run,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = run & tick & ~hold & ~ld & (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst || hold)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    // R5
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld && !hold) |=> $stable(cnt));

endmodule

// File: rtl/wdrc_stretch.sv
module wdrc_stretch #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int unsigned PW = $clog2(LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire)
            left_q <= PW'(LEN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign active = (left_q != '0);

    // R5
    len_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !active) |=> active);

endmodule

// File: rtl/wdrc_status.sv
module wdrc_status
    import wdrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_ovf,
    input  logic       rd_hit,
    input  logic       wr_hit,
    input  logic [2:0] wbits,
    output rsc_t       rsc
);

    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsc   <= '0;
            arm_q <= 1'b0;
        end else begin
            if (set_ovf)
                rsc.flag <= 1'b1;
            else if (wr_hit && arm_q && !wbits[2])
                rsc.flag <= 1'b0;
            if (wr_hit) begin
                rsc.rst_en <= wbits[1];
                rsc.spare  <= wbits[0];
                arm_q      <= 1'b0;
            end else if (rd_hit && rsc.flag) begin
                arm_q <= 1'b1;
            end
        end
    end

    // R8
    wr_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wbits[2] && rsc.flag) |=> rsc.flag);

    // R8
    armed_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rsc.flag) |-> $past(arm_q));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_ovf |=> rsc.flag);

endmodule

// File: rtl/wdrc_top.sv
module wdrc_top
    import wdrc_pkg::*;
#(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic              ivl_irq
);

    reg_addr_e         addr;
    tctl_t             tctl_q;
    rsc_t              rsc;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] cnt_ext;
    logic              wrap, wd_ovf, iv_ovf, fire, active, irq_q;

    assign addr   = reg_addr_e'(bus_addr);
    assign wd_ovf = wrap & tctl_q.wdog;
    assign iv_ovf = wrap & ~tctl_q.wdog;
    assign fire   = wd_ovf & rsc.rst_en;

    wdrc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .hold   (active),
        .run    (tctl_q.run),
        .tick   (tick),
        .ld     (bus_we && addr == A_TCNT),
        .ld_val (bus_wdata[CNT_W-1:0]),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    wdrc_stretch #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .active (active)
    );

    wdrc_status u_rsc (
        .clk     (clk),
        .rst     (rst),
        .set_ovf (wd_ovf),
        .rd_hit  (bus_re && addr == A_RSC),
        .wr_hit  (bus_we && addr == A_RSC),
        .wbits   (bus_wdata[DATA_W-1:DATA_W-3]),
        .rsc     (rsc)
    );

    always_ff @(posedge clk) begin
        if (rst || wd_ovf || active)
            tctl_q <= '0;
        else if (bus_we && addr == A_TCTL)
            tctl_q <= '{run: bus_wdata[1], wdog: bus_wdata[0]};
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= iv_ovf;
    end

    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = cnt;
    end

    always_comb begin
        case (addr)
            A_TCTL:  bus_rdata = pack_tctl(tctl_q);
            A_TCNT:  bus_rdata = cnt_ext;
            A_RSC:   bus_rdata = pack_rsc(rsc);
            default: bus_rdata = '0;
        endcase
    end

    assign sys_rst_req = active;
    assign ivl_irq     = irq_q;

    // R3
    no_ivl_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsc.flag) |-> $past(tctl_q.wdog));

    // R6
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> $past(rsc.rst_en));

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        ivl_irq |=> !ivl_irq);

    // R9
    ones_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_RSC) |-> (bus_rdata[4:0] == 5'h1F));

endmodule

// File: tb/wdrc_tb.sv
module wdrc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       sys_rst_req, ivl_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdrc_top dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req), .ivl_irq(ivl_irq)
    );

    function automatic logic [7:0] exp_rsc(bit f, bit e, bit s);
        return {f, e, s, 5'h1F};
    endfunction

    function automatic logic [7:0] exp_cnt(logic [7:0] v, int n);
        return 8'((int'(v) + n) % 256);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        int n;
        int hi;
        int unsigned r;
        r = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(2'd2, d); chk("R1 rsc", d, 8'h1F);
        rd(2'd0, d); chk("R1 tctl", d, 8'h00);
        rd(2'd1, d); chk("R1 cnt", d, 8'h00);
        chk("R1 req", {7'd0, sys_rst_req}, 8'h00);
        chk("R1 irq", {7'd0, ivl_irq}, 8'h00);

        // R2 / R9 random traffic
        for (int it = 0; it < 40; it++) begin
            r = $urandom % 3;
            v = 8'($urandom);
            n = 1 + int'($urandom % 20);
            if (r == 0) begin
                wr(2'd0, 8'h02); wr(2'd1, v); step(n);
                rd(2'd1, d); chk("R2 run", d, exp_cnt(v, n));
            end else if (r == 1) begin
                wr(2'd0, 8'h00); wr(2'd1, v); step(n);
                rd(2'd1, d); chk("R2 stop", d, v);
            end else begin
                wr(2'd2, v);
                rd(2'd2, d); chk("R9 rw", d, exp_rsc(1'b0, v[6], v[5]));
            end
        end
        wr(2'd0, 8'h00);

        // R5 reset request pulse
        wr(2'd2, 8'h40); wr(2'd1, 8'hFE); wr(2'd0, 8'h03);
        step(2);
        hi = 0;
        while (sys_rst_req && hi < 100) begin
            hi++;
            @(posedge clk); #1;
        end
        chk("R5 pulse len", 8'(hi), 8'd16);
        rd(2'd1, d); chk("R5 cnt", d, 8'h00);
        rd(2'd0, d); chk("R7 tctl", d, 8'h00);
        rd(2'd2, d); chk("R3 flag", d, exp_rsc(1'b1, 1'b1, 1'b0));

        // R8 clear protocol
        wr(2'd2, 8'hC0);
        rd(2'd2, d); chk("R8 write1", d, exp_rsc(1'b1, 1'b1, 1'b0));
        wr(2'd2, 8'hC0);
        wr(2'd2, 8'h40);
        rd(2'd2, d); chk("R8 unarmed", d, exp_rsc(1'b1, 1'b1, 1'b0));
        wr(2'd2, 8'h40);
        rd(2'd2, d); chk("R8 cleared", d, exp_rsc(1'b0, 1'b1, 1'b0));

        // R6 / R9 overflow without reset, spare set
        wr(2'd2, 8'h20); wr(2'd1, 8'hFF); wr(2'd0, 8'h03);
        step(1);
        hi = 0;
        for (int k = 0; k < 4; k++) begin
            if (sys_rst_req) hi++;
            @(posedge clk); #1;
        end
        chk("R6 no req", 8'(hi), 8'd0);
        rd(2'd1, d); chk("R6 cnt", d, 8'h00);
        rd(2'd0, d); chk("R6 tctl", d, 8'h00);
        rd(2'd2, d); chk("R7 rsc kept", d, exp_rsc(1'b1, 1'b0, 1'b1));

        // R10 wrap and armed clear in one cycle
        wr(2'd1, 8'hFF); wr(2'd0, 8'h03);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h20; bus_we = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; tick = 1'b0;
        wr(2'd2, 8'h20);
        rd(2'd2, d); chk("R10 set wins", d, exp_rsc(1'b1, 1'b0, 1'b1));
        wr(2'd2, 8'h20);
        rd(2'd2, d); chk("R8 clear", d, exp_rsc(1'b0, 1'b0, 1'b1));

        // R4 interval mode
        wr(2'd1, 8'hFF); wr(2'd0, 8'h02);
        step(1);
        chk("R4 irq hi", {7'd0, ivl_irq}, 8'h01);
        @(posedge clk); #1;
        chk("R4 irq lo", {7'd0, ivl_irq}, 8'h00);
        step(3);
        rd(2'd1, d); chk("R4 cnt", d, 8'h03);
        rd(2'd0, d); chk("R4 tctl", d, 8'h02);
        rd(2'd2, d); chk("R4 no flag", d, exp_rsc(1'b0, 1'b0, 1'b1));
        chk("R4 no req", {7'd0, sys_rst_req}, 8'h00);

        finish_run();
    end

endmodule